// File: doc/BRIEF.md
# Oscillator-Jitter Random Byte Generator with Frequency Window Monitor

This block turns the phase jitter of several free-running oscillators into random bytes. The enabled oscillator lines are masked and XOR-combined into one bit. That bit arrives asynchronously, so it passes through a two-flop synchronizer in the system clock domain. While the generator is switched on and enough oscillators take part, one new bit enters an 8-bit shift register on every clock. After every eighth new bit the collected byte is copied to the output and a ready flag is raised. The consumer pulses a read strobe to take the byte, and that strobe clears the flag.

The second part checks the frequency of the oscillator under measurement. Each time an external counter delivers a completed measurement with its valid strobe, and the monitor is switched on, the upper byte of the count is compared with an 8-bit low bound and an 8-bit high bound. The result is stored as a status byte. While the monitor is on and its last verdict was out of window, the ready flag is hidden from the consumer, so bytes are not handed out while an oscillator looks unhealthy.

Top module: `jitter_trng_health`

## Requirements
- R1: After reset, `rnd_byte` is 0, `rnd_ready` is 0 and `health_status` is 0.
- R2: The sampled bit is the XOR of `osc_in & osc_en`. A value presented before clock edge k enters the shift register at edge k+2. Bits shift in at bit 0, so the first of eight collected bits ends up in bit 7 of `rnd_byte`.
- R3: An oscillator line whose `osc_en` bit is 0 has no effect on the collected byte.
- R4: The generator advances only while `gen_en` is 1 and at least two `osc_en` bits are set. Otherwise no bit is collected, the bit count returns to zero and `rnd_ready` is not raised.
- R5: `rnd_ready` rises on the edge that collects the eighth new bit. `rnd_byte` changes only on such an edge.
- R6: A `rd_strobe` high at an edge clears the ready flag at that edge. If a byte completes on the same edge, the flag stays set.
- R7: `health_status` bit 0 means the count is below the low bound, bit 1 means it is above the high bound, and bit 2 means it is within both bounds, inclusive. Bits 7..3 are always 0.
- R8: `health_status` is updated only at an edge where `cnt_valid` and `mon_en` are both 1. At all other edges it holds its value.
- R9: While `mon_en` is 1 and `health_status` bit 0 or bit 1 is set, `rnd_ready` is 0. The flag reappears once a later result falls inside the window.
- R10: Only the upper 8 bits of `cnt_value` are compared with the bounds. The lower 8 bits do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 5 | Free-running oscillator outputs (asynchronous) |
| osc_en | input | 5 | Per-oscillator participation mask |
| gen_en | input | 1 | Generator enable |
| mon_en | input | 1 | Health monitor enable |
| cnt_valid | input | 1 | One-cycle strobe marking a completed measurement |
| cnt_value | input | 16 | Latched measurement count |
| bound_lo | input | 8 | Lower window bound (compared with count bits 15..8) |
| bound_hi | input | 8 | Upper window bound (compared with count bits 15..8) |
| rd_strobe | input | 1 | Consumer takes the current byte |
| rnd_byte | output | 8 | Most recently completed random byte |
| rnd_ready | output | 1 | A new byte is waiting (masked by an unhealthy verdict) |
| health_status | output | 8 | Below / above / inside verdict of the last checked count |

## Verification
The hardest case to reach is a read strobe that falls on the same edge as the eighth collected bit, because the bench can only see the bit count through the latency of the synchronizer. The bench drives the oscillator lines from its own clock at the falling edge, so each XOR value is known. It raises `gen_en` exactly two cycles after the first stream bit, which lines up the completion edge with a known cycle, and then places the strobe on that edge. Suppression is exercised by producing a ready byte, then delivering an out-of-window count and an in-window count in turn.

// File: rtl/jt_pkg.sv
// Package: shared constants for the jitter generator and its window monitor.
// Assumes nothing beyond the defaults being used consistently by all modules.
package jt_pkg;
    localparam int STAT_W     = 8;
    localparam int ST_BELOW   = 0;
    localparam int ST_ABOVE   = 1;
    localparam int ST_INSIDE  = 2;

    typedef enum logic [1:0] {
        WIN_BELOW  = 2'd0,
        WIN_ABOVE  = 2'd1,
        WIN_INSIDE = 2'd2
    } win_verdict_e;
endpackage

// File: rtl/jt_entropy_mix.sv
// Module: masks and XOR-combines the oscillator lines, then brings the result
// into the system clock domain through a flop chain. It also reports whether
// enough oscillators take part. Assumes osc_in is fully asynchronous to clk.
module jt_entropy_mix #(
    parameter int NUM_OSC     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_ACTIVE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_in,
    input  logic [NUM_OSC-1:0] osc_en,
    output logic               sample_bit,
    output logic               enough_en
);
    localparam int POP_W = $clog2(NUM_OSC + 1);

    logic [NUM_OSC-1:0]     masked;
    logic                   mix_raw;
    logic [SYNC_STAGES-1:0] sync_q;
    logic [POP_W-1:0]       pop;

    // combine the participating oscillator lines
    always_comb begin
        masked  = osc_in & osc_en;
        mix_raw = ^masked;
    end

    // count the enabled oscillators
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            pop = pop + POP_W'(osc_en[i]);
        end
        enough_en = (int'(pop) >= MIN_ACTIVE);
    end

    // synchronizer chain, first stage takes the raw mix
    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // capture the asynchronous mix
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= mix_raw;
                end
            end else begin : g_next
                // move the sample one stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign sample_bit = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/jt_byte_collector.sv
// Module: shifts one synchronized bit per enabled cycle into a register and
// publishes a full byte with a ready flag after BYTE_W new bits. Assumes
// 'advance' is already qualified by the enables. The bit count restarts when
// advance drops.
module jt_byte_collector #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              bit_in,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] byte_q,
    output logic              ready_q,
    output logic              fire
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nx;
    logic [CNT_W-1:0]  bit_cnt;

    // next shift value and completion of the byte
    always_comb begin
        shreg_nx = {shreg[BYTE_W-2:0], bit_in};
        fire     = advance && (bit_cnt == LAST);
    end

    // shift register and bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (advance) begin
            shreg   <= shreg_nx;
            bit_cnt <= fire ? '0 : bit_cnt + 1'b1;
        end else begin
            bit_cnt <= '0;
        end
    end

    // published byte, updated only when a byte completes
    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (fire) byte_q <= shreg_nx;
    end

    // ready flag: completion sets it and wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n)         ready_q <= 1'b0;
        else if (fire)      ready_q <= 1'b1;
        else if (rd_strobe) ready_q <= 1'b0;
    end
endmodule

// File: rtl/jt_health_window.sv
// Module: compares the upper byte of each valid measurement with a low and a
// high bound and stores a one-hot verdict. Assumes lo <= hi for a meaningful
// window. With lo > hi a count is reported below or above, never inside.
module jt_health_window #(
    parameter int BOUND_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mon_en,
    input  logic                     cnt_valid,
    input  logic [BOUND_W-1:0]       cnt_top,
    input  logic [BOUND_W-1:0]       bound_lo,
    input  logic [BOUND_W-1:0]       bound_hi,
    output logic [jt_pkg::STAT_W-1:0] status
);
    import jt_pkg::*;

    win_verdict_e           verdict;
    logic [STAT_W-1:0]      status_nx;

    // classify the measurement against the window
    always_comb begin
        if (cnt_top < bound_lo)      verdict = WIN_BELOW;
        else if (cnt_top > bound_hi) verdict = WIN_ABOVE;
        else                         verdict = WIN_INSIDE;
    end

    // encode the verdict as a status byte
    always_comb begin
        status_nx = '0;
        unique case (verdict)
            WIN_BELOW:  status_nx[ST_BELOW]  = 1'b1;
            WIN_ABOVE:  status_nx[ST_ABOVE]  = 1'b1;
            default:    status_nx[ST_INSIDE] = 1'b1;
        endcase
    end

    // status register, written only by an enabled valid measurement
    always_ff @(posedge clk) begin
        if (!rst_n)                  status <= '0;
        else if (mon_en && cnt_valid) status <= status_nx;
    end
endmodule

// File: rtl/jitter_trng_health.sv
// Module: top of the jitter random byte generator with frequency window
// monitor. Assumes the measurement count arrives already latched, with a
// one-cycle valid strobe, and that oscillator lines are asynchronous.
module jitter_trng_health #(
    parameter int NUM_OSC     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int COUNT_W     = 16,
    parameter int BOUND_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_in,
    input  logic [NUM_OSC-1:0] osc_en,
    input  logic               gen_en,
    input  logic               mon_en,
    input  logic               cnt_valid,
    input  logic [COUNT_W-1:0] cnt_value,
    input  logic [BOUND_W-1:0] bound_lo,
    input  logic [BOUND_W-1:0] bound_hi,
    input  logic               rd_strobe,
    output logic [BYTE_W-1:0]  rnd_byte,
    output logic               rnd_ready,
    output logic [jt_pkg::STAT_W-1:0] health_status
);
    import jt_pkg::*;

    localparam int LOW_W = COUNT_W - BOUND_W;

    logic               sample_bit;
    logic               enough_en;
    logic               gen_go;
    logic               ready_raw;
    logic               fire;
    logic               unhealthy;
    logic [BOUND_W-1:0] cnt_top;
    logic               cnt_low_unused;

    // split the count: the upper part is judged, the lower part is dropped
    assign cnt_top        = cnt_value[COUNT_W-1 -: BOUND_W];
    assign cnt_low_unused = ^cnt_value[LOW_W-1:0];

    jt_entropy_mix #(
        .NUM_OSC    (NUM_OSC),
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_ACTIVE (2)
    ) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_in    (osc_in),
        .osc_en    (osc_en),
        .sample_bit(sample_bit),
        .enough_en (enough_en)
    );

    // the generator runs only when enabled with enough sources
    assign gen_go = gen_en && enough_en;

    jt_byte_collector #(
        .BYTE_W(BYTE_W)
    ) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (gen_go),
        .bit_in   (sample_bit),
        .rd_strobe(rd_strobe),
        .byte_q   (rnd_byte),
        .ready_q  (ready_raw),
        .fire     (fire)
    );

    jt_health_window #(
        .BOUND_W(BOUND_W)
    ) u_health (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (mon_en),
        .cnt_valid(cnt_valid),
        .cnt_top  (cnt_top),
        .bound_lo (bound_lo),
        .bound_hi (bound_hi),
        .status   (health_status)
    );

    // hide the ready flag while the monitor reports an out-of-window count
    assign unhealthy = health_status[ST_BELOW] | health_status[ST_ABOVE];
    assign rnd_ready = ready_raw && !(mon_en && unhealthy);
endmodule

// File: rtl/jt_checker.sv
// Module: property checker for jitter_trng_health, attached with bind.
module jt_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_go,
    input logic              fire,
    input logic              ready_raw,
    input logic              rd_strobe,
    input logic              mon_en,
    input logic              cnt_valid,
    input logic              rnd_ready,
    input logic [BYTE_W-1:0] rnd_byte,
    input logic [7:0]        health_status
);
    // R4: the internal flag can only rise after an active generator cycle
    assert_ready_needs_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_raw) |-> $past(gen_go));

    // R5: the published byte moves only on a completion edge
    assert_byte_only_on_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(rnd_byte));

    // R6: a read without a completion leaves the flag clear
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fire) |=> !ready_raw);

    // R6: a completion always leaves the flag set
    assert_fire_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ready_raw);

    // R7: at most one verdict bit, upper bits zero
    assert_status_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(health_status[2:0]) && (health_status[7:3] == 5'd0));

    // R8: status holds unless an enabled valid measurement arrives
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_valid && mon_en) |=> $stable(health_status));

    // R9: no ready indication while the monitor reports a failure
    assert_suppress_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && (health_status[1:0] != 2'b00)) |-> !rnd_ready);
endmodule

bind jitter_trng_health jt_checker #(.BYTE_W(BYTE_W)) u_jt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_go       (gen_go),
    .fire         (fire),
    .ready_raw    (ready_raw),
    .rd_strobe    (rd_strobe),
    .mon_en       (mon_en),
    .cnt_valid    (cnt_valid),
    .rnd_ready    (rnd_ready),
    .rnd_byte     (rnd_byte),
    .health_status(health_status)
);

// File: tb/tb_jitter_trng_health.sv
// Directed bench: the oscillator lines are driven at falling edges, so each
// XOR sample is known. Outputs are sampled at falling edges.
module tb_jitter_trng_health;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  osc_in = '0;
    logic [4:0]  osc_en = '0;
    logic        gen_en = 1'b0;
    logic        mon_en = 1'b0;
    logic        cnt_valid = 1'b0;
    logic [15:0] cnt_value = '0;
    logic [7:0]  bound_lo = '0;
    logic [7:0]  bound_hi = '0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rnd_byte;
    logic        rnd_ready;
    logic [7:0]  health_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    jitter_trng_health dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .osc_en(osc_en),
        .gen_en(gen_en), .mon_en(mon_en), .cnt_valid(cnt_valid),
        .cnt_value(cnt_value), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .rd_strobe(rd_strobe), .rnd_byte(rnd_byte), .rnd_ready(rnd_ready),
        .health_status(health_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // lines whose XOR over 'mask' equals b; disabled lines carry 'noise'
    function automatic logic [4:0] osc_for(input logic b, input logic [4:0] mask,
                                           input logic [4:0] noise);
        logic [4:0] v;
        v = noise & ~mask;
        for (int i = 0; i < 5; i++) begin
            if (mask[i]) begin
                v[i] = b;
                break;
            end
        end
        return v;
    endfunction

    // take the current byte and confirm the flag is cleared
    task automatic do_read(input string req);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        check(req, rnd_ready, 1'b0);
    endtask

    // stream 'pat' MSB first; gen_en rises two cycles after the first bit
    task automatic collect(input logic [7:0] pat, input logic [4:0] mask,
                           input logic [4:0] noise, input bit rd_on_last,
                           input logic [7:0] exp_byte, input logic exp_rdy,
                           input string req);
        logic b;
        osc_en = mask;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            b = (i < 8) ? pat[7-i] : 1'b0;
            osc_in = osc_for(b, mask, noise ^ 5'(i * 7));
            if (i == 2) gen_en = 1'b1;
            if (i == 9 && rd_on_last) rd_strobe = 1'b1;
        end
        @(negedge clk);
        gen_en = 1'b0;
        rd_strobe = 1'b0;
        check({req, " ready"}, rnd_ready, exp_rdy);
        check({req, " byte"}, rnd_byte, exp_byte);
    endtask

    task automatic measure(input logic [15:0] cnt);
        @(negedge clk); cnt_value = cnt; cnt_valid = 1'b1;
        @(negedge clk); cnt_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 byte", rnd_byte, 8'h00);
        check("R1 ready", rnd_ready, 1'b0);
        check("R1 status", health_status, 8'h00);
    endtask

    task automatic t_stream;
        collect(8'hA5, 5'b00011, 5'b00000, 1'b0, 8'hA5, 1'b1, "R2 R5 pattern A5");
        do_read("R6 read clears");
        collect(8'h3C, 5'b10101, 5'b00000, 1'b0, 8'h3C, 1'b1, "R2 pattern 3C");
        do_read("R6 read clears 2");
    endtask

    task automatic t_noise;
        // R3: disabled lines toggle but must not alter the byte
        collect(8'h96, 5'b01100, 5'b10011, 1'b0, 8'h96, 1'b1, "R3 disabled lines ignored");
        do_read("R6 read clears 3");
    endtask

    task automatic t_too_few;
        // R4: one enabled source, byte stays at 96 and no ready
        collect(8'h5A, 5'b00100, 5'b00000, 1'b0, 8'h96, 1'b0, "R4 single source");
        // R4: gen_en low with many sources
        osc_en = 5'b11111;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); osc_in = 5'(i * 5);
        end
        check("R4 gen off ready", rnd_ready, 1'b0);
        check("R4 gen off byte", rnd_byte, 8'h96);
    endtask

    task automatic t_read_race;
        // R6: read on the completing edge, completion wins
        collect(8'hC3, 5'b00011, 5'b00000, 1'b1, 8'hC3, 1'b1, "R6 read with completion");
        do_read("R6 read after race");
    endtask

    task automatic t_health;
        mon_en = 1'b1;
        bound_lo = 8'h40; bound_hi = 8'h60;
        measure(16'h3FFF); check("R7 below", health_status, 8'h01);
        measure(16'h4000); check("R7 lo edge inside", health_status, 8'h04);
        measure(16'h60FF); check("R7 hi edge inside", health_status, 8'h04);
        measure(16'h6100); check("R7 above", health_status, 8'h02);
        // R10: low byte does not matter
        measure(16'h50FF); check("R10 low byte FF", health_status, 8'h04);
        measure(16'h3F00); check("R10 low byte 00", health_status, 8'h01);
        // R8: a valid strobe with monitor off leaves status alone
        mon_en = 1'b0;
        measure(16'h5000); check("R8 monitor off holds", health_status, 8'h01);
        // R8: no strobe, changed count, holds
        mon_en = 1'b1;
        @(negedge clk); cnt_value = 16'h5000;
        @(negedge clk); check("R8 no strobe holds", health_status, 8'h01);
    endtask

    task automatic t_suppress;
        // status is below; a finished byte must be hidden
        collect(8'h11, 5'b00011, 5'b00000, 1'b0, 8'h11, 1'b0, "R9 hidden while failing");
        mon_en = 1'b0;
        @(negedge clk); check("R9 visible with monitor off", rnd_ready, 1'b1);
        mon_en = 1'b1;
        measure(16'h5000);
        check("R9 visible after inside verdict", rnd_ready, 1'b1);
        measure(16'h7000);
        check("R9 hidden after above verdict", rnd_ready, 1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_noise();
        t_too_few();
        t_read_race();
        t_health();
        t_suppress();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule